// File: doc/BRIEF.md
# Erased Page Zero-Count Detector

This block runs next to the ECC decoder of a NAND flash read path. Raw page bytes pass it on a byte-wide stream, with a valid strobe and markers for the first and the last byte of a page. The block counts the zero bits over the whole page. When the last byte arrives it looks at the decoder's uncorrectable verdict for that page. If the decoder gave up but the page holds fewer zeros than a programmed limit, the page is treated as blank (never programmed) and not as a failed read.

The outcome goes to a 32-bit sticky status word. Software clears its bits by writing ones to them. A page-done bit is set at the end of every page. Exactly one of two further bits may be set with it: an erased-page flag or an uncorrectable flag. The erased verdict takes the place of the error flag. The block does not report how many bit flips the page held. A single 32-bit configuration word supplies the erase limit and the correction strength. The strength is passed through to the decoder.

Top module: `erased_page_detector`

## Requirements
- R1: After a synchronous active-high reset, `status` is all zeros.
- R2: Zero bits are summed over every accepted byte (`in_valid` high) from the page-start byte to the page-end byte. Bytes presented while `in_valid` is low are not counted. A page-start byte restarts the sum, and a single byte may be both start and end.
- R3: At page end, when `dec_uncor` is 1 and the page's zero total is strictly below the limit, status bit 16 (erased) is set and bit 0 (uncorrectable) is not. When the total equals or exceeds the limit, bit 0 is set and bit 16 is not.
- R4: A page ending with `dec_uncor` at 0 sets neither bit 0 nor bit 16.
- R5: The zero counter is 17 bits wide and saturates. A page of 16384 bytes of 0x00 (131072 zeros), with limit 0xFFFF and `dec_uncor` at 1, reports bit 0 and not bit 16.
- R6: A limit of 0 turns erase detection off. Every uncorrectable page then sets bit 0.
- R7: Status bit 15 (page done) is set at the end of every page, together with the erased or uncorrectable result.
- R8: `cfg_word` bits 31:16 are the erase limit, and bits 4:0 are the correction strength, which is driven on `corr_strength`. Bits 15:5 have no effect.
- R9: Status bits stay set until a cycle with `st_wr_en` high and a 1 in that bit position of `st_wr_data`. Written zeros leave bits untouched. When a clear and a new page result reach the same bit in the same cycle, the bit ends up set.
- R10: The verdict is registered on the clock edge that accepts the page-end byte. It appears in `status` after the next rising edge, and not after the first one.
- R11: With a limit of 1, only a page whose bytes are all 0xFF is reported as erased. A single zero bit makes it uncorrectable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Configuration: limit in 31:16, strength in 4:0 |
| in_valid | input | 1 | Byte on `in_data` is accepted this cycle |
| in_data | input | 8 | Raw page byte |
| in_first | input | 1 | Accepted byte is the first of a page |
| in_last | input | 1 | Accepted byte is the last of a page |
| dec_uncor | input | 1 | Decoder's uncorrectable verdict, sampled with the last byte |
| st_wr_en | input | 1 | Write-one-to-clear strobe for `status` |
| st_wr_data | input | 32 | Bits to clear |
| corr_strength | output | 5 | Correction strength for the decoder |
| status | output | 32 | Sticky status: bit 0 uncorrectable, bit 15 done, bit 16 erased |

## Verification
Counter saturation is the hardest state to reach from the ports. It needs a page with more than 131071 zeros. The stimulus streams 16384 bytes of 0x00 with the largest limit. Without saturation that count wraps to exactly zero and would read as erased. The other hard case is a clear landing on the same edge as a page result. The bench times a write-one strobe into the single cycle between the verdict register and the status update, with the erased bit already set. It expects the erased bit to be cleared and the done bit to survive.

// File: rtl/epd_pkg.sv
package epd_pkg;

    localparam int DATA_W     = 8;
    localparam int CNT_W      = 17;
    localparam int THR_W      = 16;
    localparam int STR_W      = 5;
    localparam int CFG_W      = 32;
    localparam int STATUS_W   = 32;
    localparam int THR_LSB    = 16;
    localparam int STR_LSB    = 0;
    localparam int BIT_UNCOR  = 0;
    localparam int BIT_DONE   = 15;
    localparam int BIT_ERASED = 16;
    localparam int ZW         = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [THR_W-1:0] limit;
        logic [STR_W-1:0] strength;
    } cfg_t;

    typedef struct packed {
        logic valid;
        logic erased;
        logic uncor;
    } verdict_t;

    function automatic logic [ZW-1:0] zeros_in(input logic [DATA_W-1:0] d);
        logic [ZW-1:0] n;
        n = '0;
        for (int i = 0; i < DATA_W; i++) begin
            n = n + ZW'(~d[i]);
        end
        return n;
    endfunction

    function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                 input logic [ZW-1:0] b);
        logic [CNT_W:0] s;
        s = {1'b0, a} + (CNT_W+1)'(b);
        return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/epd_cfg_decode.sv
module epd_cfg_decode
    import epd_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_word,
    output cfg_t             cfg
);
    always_comb begin
        cfg.limit    = cfg_word[THR_LSB +: THR_W];
        cfg.strength = cfg_word[STR_LSB +: STR_W];
    end
endmodule

// File: rtl/epd_zero_counter.sv
module epd_zero_counter
    import epd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic [DATA_W-1:0] in_data,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  page_total
);
    logic [CNT_W-1:0] base;

    always_comb begin
        base       = in_first ? '0 : cnt_q;
        page_total = sat_add(base, zeros_in(in_data));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (in_valid) begin
            cnt_q <= page_total;
        end
    end
endmodule

// File: rtl/epd_verdict.sv
module epd_verdict
    import epd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_last,
    input  logic             dec_uncor,
    input  logic [CNT_W-1:0] page_total,
    input  logic [THR_W-1:0] limit,
    output verdict_t         verdict_q
);
    logic below, detect_on;

    always_comb begin
        detect_on = (limit != '0);
        below     = page_total < CNT_W'(limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '0;
        end else begin
            verdict_q.valid  <= accept_last;
            verdict_q.erased <= accept_last && dec_uncor && detect_on && below;
            verdict_q.uncor  <= accept_last && dec_uncor && !(detect_on && below);
        end
    end
endmodule

// File: rtl/epd_status_reg.sv
module epd_status_reg
    import epd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  verdict_t            ev,
    input  logic                wr_en,
    input  logic [STATUS_W-1:0] wr_data,
    output logic [STATUS_W-1:0] status_q
);
    logic [STATUS_W-1:0] set_v, clr_v, status_d;

    always_comb begin
        set_v             = '0;
        set_v[BIT_DONE]   = ev.valid;
        set_v[BIT_ERASED] = ev.valid && ev.erased;
        set_v[BIT_UNCOR]  = ev.valid && ev.uncor;
        clr_v             = wr_en ? wr_data : '0;
        status_d          = (status_q & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end
endmodule

// File: rtl/erased_page_detector.sv
module erased_page_detector
    import epd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [CFG_W-1:0]    cfg_word,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   in_data,
    input  logic                in_first,
    input  logic                in_last,
    input  logic                dec_uncor,
    input  logic                st_wr_en,
    input  logic [STATUS_W-1:0] st_wr_data,
    output logic [STR_W-1:0]    corr_strength,
    output logic [STATUS_W-1:0] status
);
    cfg_t             cfg;
    logic [CNT_W-1:0] zero_cnt_q;
    logic [CNT_W-1:0] page_total;
    verdict_t         verdict_q;
    logic             ev_valid, ev_erased, ev_uncor;
    logic [THR_W-1:0] cur_limit;

    epd_cfg_decode u_cfg (
        .cfg_word (cfg_word),
        .cfg      (cfg)
    );

    epd_zero_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_first   (in_first),
        .in_data    (in_data),
        .cnt_q      (zero_cnt_q),
        .page_total (page_total)
    );

    epd_verdict u_vrd (
        .clk         (clk),
        .rst         (rst),
        .accept_last (in_valid && in_last),
        .dec_uncor   (dec_uncor),
        .page_total  (page_total),
        .limit       (cfg.limit),
        .verdict_q   (verdict_q)
    );

    epd_status_reg u_sts (
        .clk      (clk),
        .rst      (rst),
        .ev       (verdict_q),
        .wr_en    (st_wr_en),
        .wr_data  (st_wr_data),
        .status_q (status)
    );

    assign corr_strength = cfg.strength;
    assign ev_valid      = verdict_q.valid;
    assign ev_erased     = verdict_q.erased;
    assign ev_uncor      = verdict_q.uncor;
    assign cur_limit     = cfg.limit;
endmodule

// File: rtl/epd_checker.sv
module epd_checker
    import epd_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_first,
    input logic                in_last,
    input logic                st_wr_en,
    input logic [STATUS_W-1:0] st_wr_data,
    input logic [STATUS_W-1:0] status,
    input logic [CNT_W-1:0]    cnt,
    input logic                ev_valid,
    input logic                ev_erased,
    input logic                ev_uncor,
    input logic [THR_W-1:0]    limit
);
    // R3: erased and uncorrectable never reported for the same page
    a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> !(ev_erased && ev_uncor));

    // R5: a full counter stays full until the next page start
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (cnt == {CNT_W{1'b1}} && in_valid && !in_first) |=> (cnt == {CNT_W{1'b1}}));

    // R6: a zero limit never yields an erased verdict
    a_r6_limit_zero_off: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && limit == '0) |-> !ev_erased);

    // R7 / R9: a page result always leaves the done bit set, even against a clear
    a_r7_done_after_event: assert property (@(posedge clk) disable iff (rst)
        ev_valid |=> status[BIT_DONE]);

    // R9: without a write, set bits stay set
    a_r9_sticky_erased: assert property (@(posedge clk) disable iff (rst)
        (!st_wr_en && status[BIT_ERASED]) |=> status[BIT_ERASED]);

    // R9: a written zero never clears a bit
    a_r9_zero_write_keeps: assert property (@(posedge clk) disable iff (rst)
        (st_wr_en && !st_wr_data[BIT_DONE] && status[BIT_DONE]) |=> status[BIT_DONE]);

    // R10: the verdict register fires on the edge after the last byte
    a_r10_verdict_latency: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> ev_valid);

    // R7: the erased bit only rises alongside a set done bit
    a_r7_erased_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(status[BIT_ERASED]) |-> status[BIT_DONE]);
endmodule

bind erased_page_detector epd_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_first   (in_first),
    .in_last    (in_last),
    .st_wr_en   (st_wr_en),
    .st_wr_data (st_wr_data),
    .status     (status),
    .cnt        (zero_cnt_q),
    .ev_valid   (ev_valid),
    .ev_erased  (ev_erased),
    .ev_uncor   (ev_uncor),
    .limit      (cur_limit)
);

// File: tb/erased_page_detector_tb_top.sv
module erased_page_detector_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [15:0] limit;
        logic [15:0] nbytes;
        logic [7:0]  fill;
        logic [7:0]  lastb;
        logic        uncor;
        logic [2:0]  exp;   // {erased, done, uncor}
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'd1,  16'd16, 8'hFF, 8'hFF, 1'b1, 3'b110},  // R11 all 0xFF
        '{16'd1,  16'd16, 8'hFF, 8'hFE, 1'b1, 3'b011},  // R11 one zero
        '{16'd5,  16'd4,  8'hFE, 8'hFE, 1'b1, 3'b110},  // R3 4 < 5
        '{16'd4,  16'd4,  8'hFE, 8'hFE, 1'b1, 3'b011},  // R3 equal
        '{16'd100,16'd8,  8'h00, 8'h00, 1'b0, 3'b010},  // R4 clean
        '{16'd0,  16'd4,  8'hFF, 8'hFF, 1'b1, 3'b011},  // R6 off
        '{16'd9,  16'd3,  8'hF0, 8'hF0, 1'b1, 3'b011},  // R2 12 >= 9
        '{16'd13, 16'd3,  8'hF0, 8'hF0, 1'b1, 3'b110},  // R2 12 < 13
        '{16'd1,  16'd1,  8'hFF, 8'hFF, 1'b1, 3'b110}   // R2 single-byte page
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_first = 1'b0;
    logic        in_last = 1'b0;
    logic        dec_uncor = 1'b0;
    logic        st_wr_en = 1'b0;
    logic [31:0] st_wr_data = '0;
    logic [4:0]  corr_strength;
    logic [31:0] status;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    erased_page_detector dut_i (
        .clk(clk), .rst(rst), .cfg_word(cfg_word),
        .in_valid(in_valid), .in_data(in_data), .in_first(in_first),
        .in_last(in_last), .dec_uncor(dec_uncor), .st_wr_en(st_wr_en),
        .st_wr_data(st_wr_data), .corr_strength(corr_strength), .status(status)
    );

    function automatic logic [31:0] mk(input logic e, input logic d, input logic u);
        return (32'(e) << 16) | (32'(d) << 15) | 32'(u);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_page(input int n, input logic [7:0] fill, input logic [7:0] lastb,
                             input logic uncor, input bit gaps);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_data   = (i == n-1) ? lastb : fill;
            in_first  = (i == 0);
            in_last   = (i == n-1);
            dec_uncor = uncor;
            if (gaps && i != n-1) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_data  = 8'h00;
                in_first = 1'b0;
                in_last  = 1'b0;
            end
        end
        @(negedge clk);
        in_valid  = 1'b0;
        in_first  = 1'b0;
        in_last   = 1'b0;
        in_data   = 8'h00;
        dec_uncor = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        st_wr_en   = 1'b1;
        st_wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        st_wr_en   = 1'b0;
        st_wr_data = '0;
    endtask

    task automatic write_clr(input logic [31:0] d);
        st_wr_en   = 1'b1;
        st_wr_data = d;
        @(negedge clk);
        st_wr_en   = 1'b0;
        st_wr_data = '0;
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog: actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cfg_word = {16'd1, 11'h7FF, 5'h13};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset status", status, 32'h0);
        check("R8 strength bits 4:0", 32'(corr_strength), 32'h13);

        // table walk; junk always present in cfg bits 15:5 (R8)
        for (int v = 0; v < NV; v++) begin
            clear_all();
            check("R9 clear-all empties status", status, 32'h0);
            cfg_word = {VECS[v].limit, 11'h5A5, 5'(v + 3)};
            send_page(int'(VECS[v].nbytes), VECS[v].fill, VECS[v].lastb, VECS[v].uncor, 1'b0);
            @(negedge clk);
            check($sformatf("R3/R8 vector %0d status", v), status,
                  mk(VECS[v].exp[2], VECS[v].exp[1], VECS[v].exp[0]));
            check($sformatf("R8 vector %0d strength", v), 32'(corr_strength), 32'(v + 3));
        end

        // R10 latency
        clear_all();
        cfg_word = {16'd1, 16'h0000};
        send_page(2, 8'hFF, 8'hFF, 1'b1, 1'b0);
        check("R10 not yet after first edge", status, 32'h0);
        @(negedge clk);
        check("R10 set after second edge", status, mk(1, 1, 0));

        // R9 sticky across idle and a clean page
        repeat (4) @(negedge clk);
        check("R9 sticky idle", status, mk(1, 1, 0));
        send_page(3, 8'h00, 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        check("R4 clean page keeps old bits", status, mk(1, 1, 0));
        write_clr(32'h0000_7FFF);
        check("R9 zero bits in write do nothing to 15/16", status, mk(1, 1, 0));
        write_clr(32'h0000_8000);
        check("R9 clear only done bit", status, mk(1, 0, 0));

        // R9 collision: clear-all meets a clean-page result
        send_page(2, 8'h00, 8'h00, 1'b0, 1'b0);
        write_clr(32'hFFFF_FFFF);
        check("R9 event wins over clear", status, mk(0, 1, 0));

        // R2 gaps of invalid 0x00 not counted
        clear_all();
        cfg_word = {16'd5, 16'h0000};
        send_page(4, 8'hFE, 8'hFE, 1'b1, 1'b1);
        @(negedge clk);
        check("R2 invalid bytes ignored", status, mk(1, 1, 0));

        // R8 bits 15:5 ignored with limit 2
        clear_all();
        cfg_word = {16'd2, 11'h7FF, 5'h00};
        send_page(2, 8'hFF, 8'hFE, 1'b1, 1'b0);
        @(negedge clk);
        check("R8 middle bits ignored", status, mk(1, 1, 0));
        check("R8 strength zero", 32'(corr_strength), 32'h0);

        // R5 saturation: 131072 zeros would wrap to 0
        clear_all();
        cfg_word = {16'hFFFF, 16'h0000};
        send_page(16384, 8'h00, 8'h00, 1'b1, 1'b0);
        @(negedge clk);
        check("R5 saturated count not erased", status, mk(0, 1, 1));

        // R1 reset again after activity
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears status", status, 32'h0);

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule